// File: doc/BRIEF.md
# Branch Marker Spill and Refill Unit

This unit keeps sparse branch-predictor markers alive across an instruction cache eviction. When a line leaves the instruction cache, it takes up to two branch markers for that line and compresses them into a 17-bit field. That field is stored in spare check bits of the same line in the next cache level. The packing happens only when the line holds nothing but instructions. A line with data in it gets an all-zero field.

A small direct-mapped table, indexed by the low bits of the line address and tagged with the rest, records which lines in the next level still carry trustworthy markers. A store that hits such a line clears its table entry. Any later refill of that line then ignores the spare bits it brings back.

On refill, if the spare field says markers are present and the table still vouches for the line, the unit sends one marker-write request to the sparse predictor for each valid marker, on consecutive cycles. A refill from any requester restores the markers, not only a refill from the one that evicted the line.

Top module: `brm_spill_unit`

## Requirements
- R1: An eviction sampled on a clock edge drives `spill_valid` high for exactly one cycle after that edge, with the packed field on `spill_bits` in the same cycle. With no eviction, `spill_valid` is low.
- R2: Each marker byte is laid out as bit 7 = valid, bits 6:2 = end offset, bits 1:0 = branch kind. The spill field is laid out as bit 16 = present, bits 15:8 = slot 0 and bits 7:0 = slot 1.
- R3: Packing keeps only valid markers and moves them toward slot 0 in input order, so marker 0 comes before marker 1. A slot with no marker is all zero. The present bit is set exactly when the line is instruction-only and at least one marker is valid.
- R4: Evicting a line that is not instruction-only yields an all-zero spill field and invalidates the table entry at that line's index, whatever tag it held.
- R5: The table is direct-mapped on the low `IDX_W` bits of the line address and stores the remaining bits as a tag. An eviction with the present bit set writes its line into that entry and displaces any other line that shares the index.
- R6: A store snoop that hits a valid entry with a matching tag clears it. If an eviction and a snoop name the same line in the same cycle, the entry ends up clear.
- R7: A refill whose spare present bit is set and whose line hits the table issues one predictor write per valid slot. Slot 0 goes first. The first write appears the cycle after the refill is sampled and the second write the cycle after that. Each write carries the refill line, the slot number and the slot's end offset and kind.
- R8: A refill that misses the table, or whose spare present bit is clear, issues no predictor write.
- R9: `refill_ready` is low only during the cycle in which a second write is still pending. A refill offered in that cycle is dropped and produces no write.
- R10: A refill leaves the table unchanged, so a second refill of the same line, from any requester, restores the markers again.
- R11: After reset, the outputs are idle, `refill_ready` is high and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | Eviction request this cycle |
| evict_line | input | ADDR_W | Line address of the evicted line |
| evict_instr_only | input | 1 | Evicted line holds instructions only |
| evict_mark0 | input | 8 | First branch marker of the line |
| evict_mark1 | input | 8 | Second branch marker of the line |
| spill_valid | output | 1 | Packed spare field is valid |
| spill_bits | output | 17 | Packed spare field for the lower-level line |
| refill_valid | input | 1 | Refill into the instruction cache this cycle |
| refill_line | input | ADDR_W | Line address of the refill |
| refill_spare | input | 17 | Spare field returned with the line |
| refill_ready | output | 1 | Unit can accept a refill this cycle |
| snoop_valid | input | 1 | Store snoop to the lower level this cycle |
| snoop_line | input | ADDR_W | Line address written by the store |
| pred_wr_valid | output | 1 | Predictor marker write request |
| pred_wr_line | output | ADDR_W | Line the marker belongs to |
| pred_wr_slot | output | 1 | Slot number of the marker being written |
| pred_wr_end | output | 5 | End offset of the branch |
| pred_wr_kind | output | 2 | Branch kind |

## Verification
The bench targets the following corner cases, and states what a wrong design would do in each:
- A marker set with only the second marker valid. A design that skipped compaction would leave slot 0 empty and write the marker under slot 1.
- Mixed-content evictions. A design that wrongly kept markers would later restore them, and one that failed to clear the index would keep honouring a stale entry.
- Aliasing lines that share a table index, and stores that land before a refill, including in the same cycle as the eviction. These expose a design that restores markers the lower level no longer guarantees.
- A refill offered while a second write is pending. This catches a design that silently merges or overwrites the pending marker.

// File: rtl/brm_pkg.sv
package brm_pkg;
    localparam int END_W   = 5;
    localparam int KIND_W  = 2;
    localparam int MARK_W  = 1 + END_W + KIND_W;
    localparam int SPARE_W = 1 + 2 * MARK_W;

    typedef struct packed {
        logic              vld;
        logic [END_W-1:0]  end_ofs;
        logic [KIND_W-1:0] kind;
    } brm_mark_t;

    typedef struct packed {
        logic      present;
        brm_mark_t slot0;
        brm_mark_t slot1;
    } brm_spare_t;
endpackage

// File: rtl/brm_pack.sv
module brm_pack
    import brm_pkg::*;
(
    input  logic       instr_only,
    input  brm_mark_t  mark0,
    input  brm_mark_t  mark1,
    output brm_spare_t spare
);
    brm_mark_t m0_clean;
    brm_mark_t m1_clean;

    always_comb begin
        m0_clean = mark0.vld ? mark0 : '0;
        m1_clean = mark1.vld ? mark1 : '0;
        spare    = '0;
        if (instr_only) begin
            if (m0_clean.vld) begin
                spare.slot0 = m0_clean;
                spare.slot1 = m1_clean;
            end else begin
                spare.slot0 = m1_clean;
                spare.slot1 = '0;
            end
            spare.present = m0_clean.vld | m1_clean.vld;
        end
    end
endmodule

// File: rtl/brm_tag_table.sv
module brm_tag_table #(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_set,
    input  logic [ADDR_W-1:0] wr_line,
    input  logic              snoop_en,
    input  logic [ADDR_W-1:0] snoop_line,
    input  logic [ADDR_W-1:0] look_line,
    output logic              look_hit
);
    localparam int TAG_W   = ADDR_W - IDX_W;
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } ent_t;

    ent_t tbl_d [ENTRIES];
    ent_t tbl_q [ENTRIES];

    logic [IDX_W-1:0] wr_idx, sn_idx, lk_idx;
    logic [TAG_W-1:0] wr_tag, sn_tag, lk_tag;

    assign wr_idx = wr_line[IDX_W-1:0];
    assign wr_tag = wr_line[ADDR_W-1:IDX_W];
    assign sn_idx = snoop_line[IDX_W-1:0];
    assign sn_tag = snoop_line[ADDR_W-1:IDX_W];
    assign lk_idx = look_line[IDX_W-1:0];
    assign lk_tag = look_line[ADDR_W-1:IDX_W];

    assign look_hit = tbl_q[lk_idx].vld && (tbl_q[lk_idx].tag == lk_tag);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_comb begin
            tbl_d[e] = tbl_q[e];
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                tbl_d[e].vld = wr_set;
                tbl_d[e].tag = wr_tag;
            end
            if (snoop_en && (sn_idx == IDX_W'(e)) && (tbl_d[e].tag == sn_tag)) begin
                tbl_d[e].vld = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) tbl_q[e] <= '0;
            else        tbl_q[e] <= tbl_d[e];
        end

        assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (snoop_en && (sn_idx == IDX_W'(e)))
            |=> !(tbl_q[e].vld && (tbl_q[e].tag == $past(sn_tag))));

        assert_evict_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_set && (wr_idx == IDX_W'(e)) && !(snoop_en && (snoop_line == wr_line)))
            |=> (tbl_q[e].vld && (tbl_q[e].tag == $past(wr_tag))));

        assert_mixed_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_set && (wr_idx == IDX_W'(e))) |=> !tbl_q[e].vld);
    end
endmodule

// File: rtl/brm_refill_seq.sv
module brm_refill_seq
    import brm_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refill_valid,
    input  logic [ADDR_W-1:0] refill_line,
    input  brm_spare_t        refill_spare,
    input  logic              table_hit,
    output logic              refill_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_line,
    output logic              wr_slot,
    output brm_mark_t         wr_mark
);
    typedef struct packed {
        logic              pend;
        brm_mark_t         pend_mark;
        logic              out_v;
        logic              out_slot;
        brm_mark_t         out_mark;
        logic [ADDR_W-1:0] line;
    } seq_t;

    seq_t s_d, s_q;
    logic take;

    assign refill_ready = !s_q.pend;
    assign take = refill_ready && refill_valid && table_hit && refill_spare.present;

    always_comb begin
        s_d          = s_q;
        s_d.pend     = 1'b0;
        s_d.out_v    = 1'b0;
        s_d.out_slot = 1'b0;
        s_d.out_mark = '0;
        if (s_q.pend) begin
            s_d.out_v     = 1'b1;
            s_d.out_slot  = 1'b1;
            s_d.out_mark  = s_q.pend_mark;
            s_d.pend_mark = '0;
        end else if (take) begin
            s_d.line = refill_line;
            if (refill_spare.slot0.vld) begin
                s_d.out_v     = 1'b1;
                s_d.out_mark  = refill_spare.slot0;
                s_d.pend      = refill_spare.slot1.vld;
                s_d.pend_mark = refill_spare.slot1;
            end else if (refill_spare.slot1.vld) begin
                s_d.out_v    = 1'b1;
                s_d.out_slot = 1'b1;
                s_d.out_mark = refill_spare.slot1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_valid = s_q.out_v;
    assign wr_line  = s_q.line;
    assign wr_slot  = s_q.out_slot;
    assign wr_mark  = s_q.out_mark;

    assert_busy_mid_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !refill_ready |-> (wr_valid && !wr_slot));

    assert_no_write_unless_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_ready && !(refill_valid && table_hit && refill_spare.present)) |=> !wr_valid);

    assert_write_carries_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_mark.vld);
endmodule

// File: rtl/brm_spill_unit.sv
module brm_spill_unit
    import brm_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_line,
    input  logic              evict_instr_only,
    input  logic [7:0]        evict_mark0,
    input  logic [7:0]        evict_mark1,
    output logic              spill_valid,
    output logic [16:0]       spill_bits,
    input  logic              refill_valid,
    input  logic [ADDR_W-1:0] refill_line,
    input  logic [16:0]       refill_spare,
    output logic              refill_ready,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_line,
    output logic              pred_wr_valid,
    output logic [ADDR_W-1:0] pred_wr_line,
    output logic              pred_wr_slot,
    output logic [4:0]        pred_wr_end,
    output logic [1:0]        pred_wr_kind
);
    typedef struct packed {
        logic       v;
        brm_spare_t bits;
    } spill_t;

    brm_spare_t packed_spare;
    spill_t     sp_d, sp_q;
    logic       hit;
    brm_mark_t  wr_mark;

    brm_pack u_pack (
        .instr_only (evict_instr_only),
        .mark0      (brm_mark_t'(evict_mark0)),
        .mark1      (brm_mark_t'(evict_mark1)),
        .spare      (packed_spare)
    );

    brm_tag_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (evict_valid),
        .wr_set     (packed_spare.present),
        .wr_line    (evict_line),
        .snoop_en   (snoop_valid),
        .snoop_line (snoop_line),
        .look_line  (refill_line),
        .look_hit   (hit)
    );

    brm_refill_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .refill_valid (refill_valid),
        .refill_line  (refill_line),
        .refill_spare (brm_spare_t'(refill_spare)),
        .table_hit    (hit),
        .refill_ready (refill_ready),
        .wr_valid     (pred_wr_valid),
        .wr_line      (pred_wr_line),
        .wr_slot      (pred_wr_slot),
        .wr_mark      (wr_mark)
    );

    always_comb begin
        sp_d      = '0;
        sp_d.v    = evict_valid;
        if (evict_valid) sp_d.bits = packed_spare;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign spill_valid  = sp_q.v;
    assign spill_bits   = sp_q.bits;
    assign pred_wr_end  = wr_mark.end_ofs;
    assign pred_wr_kind = wr_mark.kind;

    assert_evict_spills_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> spill_valid);

    assert_idle_no_spill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_valid |=> !spill_valid);

    assert_mixed_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !evict_instr_only) |=> (spill_bits == '0));

    assert_absent_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_valid && !spill_bits[16]) |-> (spill_bits[15:0] == '0));
endmodule

// File: tb/brm_spill_unit_test.sv
`timescale 1ns/1ps
module brm_spill_unit_test;
    localparam int AW = 20;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evict_valid = 0, evict_instr_only = 0;
    logic [AW-1:0] evict_line = '0;
    logic [7:0] evict_mark0 = '0, evict_mark1 = '0;
    logic spill_valid;
    logic [16:0] spill_bits;
    logic refill_valid = 0;
    logic [AW-1:0] refill_line = '0;
    logic [16:0] refill_spare = '0;
    logic refill_ready;
    logic snoop_valid = 0;
    logic [AW-1:0] snoop_line = '0;
    logic pred_wr_valid, pred_wr_slot;
    logic [AW-1:0] pred_wr_line;
    logic [4:0] pred_wr_end;
    logic [1:0] pred_wr_kind;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic mdl_vld [16];
    logic [AW-IW-1:0] mdl_tag [16];
    logic [16:0] last_spill [16];

    always #2.5 clk = ~clk;

    brm_spill_unit #(.ADDR_W(AW), .IDX_W(IW)) uut (.*);

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2/R3 packing computed from the stated layout
    function automatic logic [16:0] exp_spill(logic io, logic [7:0] a, logic [7:0] b);
        logic [7:0] s [2];
        int n = 0;
        s[0] = '0; s[1] = '0;
        if (!io) return '0;
        if (a[7]) begin s[n] = a; n++; end
        if (b[7]) begin s[n] = b; n++; end
        return {n != 0, s[0], s[1]};
    endfunction

    function automatic logic mdl_hit(logic [AW-1:0] l);
        return mdl_vld[l[IW-1:0]] && mdl_tag[l[IW-1:0]] == l[AW-1:IW];
    endfunction

    task automatic evict_op(logic [AW-1:0] l, logic io, logic [7:0] a, logic [7:0] b, bit with_snoop);
        logic [16:0] e;
        e = exp_spill(io, a, b);
        @(negedge clk);
        evict_valid = 1; evict_line = l; evict_instr_only = io;
        evict_mark0 = a; evict_mark1 = b;
        snoop_valid = with_snoop; snoop_line = l;
        @(negedge clk);
        evict_valid = 0; snoop_valid = 0;
        chk(spill_valid == 1'b1, "R1 spill_valid", spill_valid, 1);
        chk(spill_bits == e, io ? "R3 packed field" : "R4 mixed zero", spill_bits, e);
        mdl_vld[l[IW-1:0]] = e[16] && !with_snoop;
        mdl_tag[l[IW-1:0]] = l[AW-1:IW];
        last_spill[l[IW-1:0]] = e;
        @(negedge clk);
        chk(spill_valid == 1'b0, "R1 single pulse", spill_valid, 0);
    endtask

    task automatic snoop_op(logic [AW-1:0] l);
        @(negedge clk);
        snoop_valid = 1; snoop_line = l;
        @(negedge clk);
        snoop_valid = 0;
        if (mdl_hit(l)) mdl_vld[l[IW-1:0]] = 0;
    endtask

    task automatic chk_wr(bit ev, bit es, logic [7:0] em, logic [AW-1:0] el, string req);
        chk(pred_wr_valid == ev, req, pred_wr_valid, ev);
        if (ev) begin
            chk(pred_wr_slot == es, {req, " slot"}, pred_wr_slot, es);
            chk({pred_wr_end, pred_wr_kind} == em[6:0], {req, " marker"},
                {pred_wr_end, pred_wr_kind}, em[6:0]);
            chk(pred_wr_line == el, {req, " line"}, pred_wr_line, el);
        end
    endtask

    task automatic refill_op(logic [AW-1:0] l, logic [16:0] sp, bit probe);
        bit take, two;
        logic [7:0] s0, s1;
        s0 = sp[15:8]; s1 = sp[7:0];
        take = mdl_hit(l) && sp[16];
        two = take && s0[7] && s1[7];
        @(negedge clk);
        refill_valid = 1; refill_line = l; refill_spare = sp;
        @(negedge clk);
        refill_valid = probe;
        if (!take)       chk_wr(0, 0, 0, l, "R8 no write");
        else if (s0[7])  chk_wr(1, 0, s0, l, "R7 first write");
        else if (s1[7])  chk_wr(1, 1, s1, l, "R7 lone slot1 write");
        else             chk_wr(0, 0, 0, l, "R7 no valid slot");
        chk(refill_ready == !two, "R9 ready", refill_ready, !two);
        @(negedge clk);
        refill_valid = 0;
        if (two) chk_wr(1, 1, s1, l, "R7 second write");
        else     chk_wr(0, 0, 0, l, "R7 single write only");
        @(negedge clk);
        chk_wr(0, 0, 0, l, probe ? "R9 dropped refill" : "R7 idle after");
        chk(refill_ready == 1'b1, "R9 ready back", refill_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] la, lb;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin mdl_vld[i] = 0; mdl_tag[i] = '0; last_spill[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk(spill_valid == 0 && pred_wr_valid == 0, "R11 idle outputs", {spill_valid, pred_wr_valid}, 0);
        chk(refill_ready == 1, "R11 ready", refill_ready, 1);
        refill_op(20'h00013, {1'b1, 8'h85, 8'h9A}, 0);            // R11 empty table

        la = 20'h00025; lb = 20'h00035;                             // same index, different tag
        evict_op(la, 1, 8'h00, 8'hC6, 0);                           // R3 only second marker valid
        refill_op(la, last_spill[5], 0);
        evict_op(la, 1, 8'hA1, 8'h8E, 0);
        refill_op(la, last_spill[5], 1);                            // R9 probe during pending
        refill_op(la, last_spill[5], 0);                            // R10 second refill restores
        evict_op(lb, 1, 8'h93, 8'h00, 0);                           // R5 displaces la
        refill_op(la, {1'b1, 8'hA1, 8'h8E}, 0);
        refill_op(lb, last_spill[5], 0);
        evict_op(lb, 0, 8'hFF, 8'hFF, 0);                           // R4 mixed line clears
        refill_op(lb, {1'b1, 8'h93, 8'h00}, 0);
        evict_op(la, 1, 8'h8F, 8'hB0, 0);
        snoop_op(la);                                               // R6 store cancels
        refill_op(la, {1'b1, 8'h8F, 8'hB0}, 0);
        evict_op(la, 1, 8'h8F, 8'hB0, 1);                           // R6 same-cycle snoop
        refill_op(la, {1'b1, 8'h8F, 8'hB0}, 0);
        evict_op(lb, 1, 8'h7F, 8'h7F, 0);                           // no valid markers
        refill_op(lb, {1'b0, 8'h9F, 8'h9F}, 0);                     // R8 present clear

        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] l;
            int op;
            l = {18'($urandom_range(0, 2)), 2'($urandom_range(0, 3))};
            op = $urandom_range(0, 9);
            if (op < 4)
                evict_op(l, $urandom_range(0, 3) != 0, 8'($urandom), 8'($urandom), $urandom_range(0, 7) == 0);
            else if (op < 6)
                snoop_op(l);
            else
                refill_op(l, ($urandom_range(0, 3) != 0) ? last_spill[l[IW-1:0]] : 17'($urandom),
                          $urandom_range(0, 1) == 1 && mdl_hit(l) && last_spill[l[IW-1:0]][16]
                          && last_spill[l[IW-1:0]][15] && last_spill[l[IW-1:0]][7] && 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule